// File: doc/BRIEF.md
# Three-Level Interrupt Aggregator

This block gathers 256 peripheral interrupt inputs into a single host interrupt output. Software reaches it over a byte-wide register bus with a 10-bit address. The lines are grouped into 32 blocks of 8. The blocks are grouped under 4 masters of 8 blocks each. A root register shows which masters have pending work, a master register shows which of its blocks do, and a block status byte shows which lines do.

The block registers are indirect. Software first writes a block number into a select register. The status, raw-level and configuration registers then act on that block. Each line has its own trigger setting: edge or level, a rising/active-high enable, a falling/active-low enable, and a clear. These settings are written through one shared configuration register. Its data byte names the line within the selected block and carries a write-enable bit.

A handler walks the tree from root to master to block. It then acknowledges a line with one configuration write that both masks and clears it. Rewriting the stored setting without the clear bit unmasks the line again.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset every line is in edge mode with both enables off and nothing pending. The select register reads 0, every status register reads 0, and `host_irq` is low.
- R2: Registers sit at a base of 0x1BB, at these offsets: root +0, master status 1 to 4 at +1 to +4, block select +5, block status +6, configuration +7, raw level +8. Any other address reads 0, and a write to it changes nothing.
- R3: Root bit 0 always reads 0, and root bit n+1 is set when master n has an active block. Bit b of master register k (offset k+1) is set when block 8k+b has an active line. Line number = 8*block + bit.
- R4: The configuration byte has these fields: bit0 level mode, bit1 falling/active-low disable, bit2 rising/active-high disable, bit3 clear, bits6:4 line within the selected block, bit7 write enable. A write with bit7 at 0 changes no line.
- R5: In edge mode, a rising edge sets the pending bit if bit2 is 0, and a falling edge sets it if bit1 is 0. Both may be enabled together. Pending holds until cleared. An input change shows at `host_irq` after the third rising clock edge, and not earlier.
- R6: In level mode, pending follows the synchronised input: high-true if bit2 is 0, low-true if bit1 is 0, and always 0 if both are 1.
- R7: An enabled configuration write with bit3 set clears the edge-mode pending bit of the addressed line. Bits 1, 2 and 3 set together mask and acknowledge in one write. Rewriting the setting with bit3 clear unmasks the line, and new edges are caught again.
- R8: The block status register reads the pending bits of the selected block, each gated off while both of its enables are off. A pending bit that is masked but not cleared reappears when the line is unmasked.
- R9: The raw-level register reads the two-flop synchronised input levels of the selected block.
- R10: `host_irq` is high exactly when some line is pending and enabled.
- R11: A write to the select register stores data bits 4:0, and a read returns that value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_lines | input | 256 | Peripheral interrupt inputs, asynchronous |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
The assertions assume that `bus_wr` is a single-cycle pulse and that the address and data are steady across the clock edge that takes them. They also assume the interrupt inputs can change at any time, because the only thing that consumes them is the synchroniser. The bench drives bus signals and inputs only on falling clock edges and holds each write for exactly one rising edge. It changes one line at a time during the trigger sweep, so every expected register value follows from a single line index.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

  // Per-line trigger setting; bit order matches the configuration byte bits 2:0
  typedef struct packed {
    logic mask_re;  // bit2: rising / active-high disabled
    logic mask_fe;  // bit1: falling / active-low disabled
    logic lvl;      // bit0: level mode
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{mask_re: 1'b1, mask_fe: 1'b1, lvl: 1'b0};

  // Register offsets from the base address
  localparam int OFS_ROOT = 0;
  localparam int OFS_MST  = 1;
  localparam int OFS_SEL  = 5;
  localparam int OFS_STAT = 6;
  localparam int OFS_CFG  = 7;
  localparam int OFS_RAW  = 8;

  // Configuration byte fields
  localparam int CFG_WE_BIT  = 7;
  localparam int CFG_CLR_BIT = 3;
  localparam int CFG_IDX_LSB = 4;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_out = hold_q;
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_tree_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_in,
  input  logic      cfg_hit,
  input  line_cfg_t cfg_wdata,
  input  logic      cfg_clr,
  output logic      raw_lvl,
  output logic      active
);
  logic      sync1_q, sync2_q, prev_q;
  logic      pend_q, pend_d;
  line_cfg_t cfg_q;
  logic      rise, fall, edge_set, lvl_qual;

  // next-state logic
  always_comb begin
    rise     = sync2_q & ~prev_q;
    fall     = ~sync2_q & prev_q;
    edge_set = (~cfg_q.mask_re & rise) | (~cfg_q.mask_fe & fall);
    lvl_qual = (~cfg_q.mask_re & sync2_q) | (~cfg_q.mask_fe & ~sync2_q);
    if (cfg_q.lvl) begin
      pend_d = lvl_qual;
    end else begin
      pend_d = (pend_q & ~(cfg_hit & cfg_clr)) | edge_set;
    end
  end

  // input synchroniser and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= line_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  // trigger setting, enabled by an addressed configuration write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_hit) begin
      cfg_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign raw_lvl = sync2_q;
  assign active  = pend_q & ~(cfg_q.mask_re & cfg_q.mask_fe);

  // R4: the setting only moves on an addressed, enabled write
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> $stable(cfg_q));

  // R5: an edge-mode pending bit stays set without a configuration write
  assert_edge_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.lvl && pend_q && !cfg_hit) |=> pend_q);

  // R6: level mode with both polarities disabled never pends
  assert_lvl_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.lvl && cfg_q.mask_re && cfg_q.mask_fe) |=> !pend_q);

  // R7: a clear with no new edge empties an edge-mode pending bit
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.lvl && cfg_hit && cfg_clr && !edge_set) |=> !pend_q);
endmodule

// File: rtl/irq_status_tree.sv
module irq_status_tree #(
  parameter int NUM_LINES         = 256,
  parameter int LINES_PER_BLOCK   = 8,
  parameter int BLOCKS_PER_MASTER = 8,
  localparam int NUM_BLOCKS  = NUM_LINES / LINES_PER_BLOCK,
  localparam int NUM_MASTERS = NUM_BLOCKS / BLOCKS_PER_MASTER
) (
  input  logic [NUM_LINES-1:0]   active,
  output logic [NUM_BLOCKS-1:0]  block_bits,
  output logic [NUM_MASTERS-1:0] master_bits,
  output logic                   host_irq
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign block_bits[b] = |active[b*LINES_PER_BLOCK +: LINES_PER_BLOCK];
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    assign master_bits[m] = |block_bits[m*BLOCKS_PER_MASTER +: BLOCKS_PER_MASTER];
  end

  assign host_irq = |master_bits;
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W            = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB,
  parameter int NUM_LINES         = 256,
  parameter int LINES_PER_BLOCK   = 8,
  parameter int BLOCKS_PER_MASTER = 8,
  localparam int NUM_BLOCKS  = NUM_LINES / LINES_PER_BLOCK,
  localparam int NUM_MASTERS = NUM_BLOCKS / BLOCKS_PER_MASTER,
  localparam int BLK_W       = $clog2(NUM_BLOCKS),
  localparam int BIT_W       = $clog2(LINES_PER_BLOCK),
  localparam int LINE_W      = BLK_W + BIT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic [NUM_LINES-1:0]   active,
  input  logic [NUM_LINES-1:0]   raw,
  input  logic [NUM_BLOCKS-1:0]  block_bits,
  input  logic [NUM_MASTERS-1:0] master_bits,
  output logic                   cfg_we,
  output logic [LINE_W-1:0]      cfg_line,
  output line_cfg_t              cfg_data,
  output logic                   cfg_clr
);
  localparam logic [ADDR_W-1:0] A_ROOT = BASE_ADDR + ADDR_W'(OFS_ROOT);
  localparam logic [ADDR_W-1:0] A_MST  = BASE_ADDR + ADDR_W'(OFS_MST);
  localparam logic [ADDR_W-1:0] A_SEL  = BASE_ADDR + ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CFG  = BASE_ADDR + ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_RAW  = BASE_ADDR + ADDR_W'(OFS_RAW);

  logic [BLK_W-1:0] sel_q, sel_d;
  logic             sel_en;
  logic [7:0]       root_byte;
  logic             in_map;

  // block select next state
  always_comb begin
    sel_en = bus_wr && (bus_addr == A_SEL);
    sel_d  = bus_wdata[BLK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  // configuration write fan-out to the addressed line
  always_comb begin
    cfg_we   = bus_wr && (bus_addr == A_CFG) && bus_wdata[CFG_WE_BIT];
    cfg_line = {sel_q, bus_wdata[CFG_IDX_LSB +: BIT_W]};
    cfg_data = line_cfg_t'(bus_wdata[2:0]);
    cfg_clr  = bus_wdata[CFG_CLR_BIT];
  end

  // read mux
  always_comb begin
    root_byte = '0;
    root_byte[NUM_MASTERS:1] = master_bits;
    in_map    = (bus_addr >= A_ROOT) && (bus_addr <= A_RAW);
    bus_rdata = '0;
    if (bus_addr == A_ROOT) bus_rdata = root_byte;
    for (int k = 0; k < NUM_MASTERS; k++) begin
      if (bus_addr == A_MST + ADDR_W'(k)) begin
        bus_rdata = 8'(block_bits[k*BLOCKS_PER_MASTER +: BLOCKS_PER_MASTER]);
      end
    end
    if (bus_addr == A_SEL)  bus_rdata = 8'(sel_q);
    if (bus_addr == A_STAT) bus_rdata = 8'(active[sel_q*LINES_PER_BLOCK +: LINES_PER_BLOCK]);
    if (bus_addr == A_RAW)  bus_rdata = 8'(raw[sel_q*LINES_PER_BLOCK +: LINES_PER_BLOCK]);
  end

  // R11: the select register takes the low data bits of its write
  assert_sel_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SEL) |=> (sel_q == $past(bus_wdata[BLK_W-1:0])));

  // R2: addresses outside the map read as zero
  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_map |-> (bus_rdata == 8'h00));

  // R3: root bit 0 never reports a master
  assert_root_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ROOT) |-> !bus_rdata[0]);
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W            = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB,
  parameter int NUM_LINES         = 256,
  parameter int LINES_PER_BLOCK   = 8,
  parameter int BLOCKS_PER_MASTER = 8,
  localparam int NUM_BLOCKS  = NUM_LINES / LINES_PER_BLOCK,
  localparam int NUM_MASTERS = NUM_BLOCKS / BLOCKS_PER_MASTER,
  localparam int LINE_W      = $clog2(NUM_BLOCKS) + $clog2(LINES_PER_BLOCK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 host_irq
);
  logic                   rst_n_s;
  logic [NUM_LINES-1:0]   active;
  logic [NUM_LINES-1:0]   raw;
  logic [NUM_BLOCKS-1:0]  block_bits;
  logic [NUM_MASTERS-1:0] master_bits;
  logic                   cfg_we;
  logic [LINE_W-1:0]      cfg_line;
  line_cfg_t              cfg_data;
  logic                   cfg_clr;

  irq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  irq_regif #(
    .ADDR_W            (ADDR_W),
    .BASE_ADDR         (BASE_ADDR),
    .NUM_LINES         (NUM_LINES),
    .LINES_PER_BLOCK   (LINES_PER_BLOCK),
    .BLOCKS_PER_MASTER (BLOCKS_PER_MASTER)
  ) u_regif (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .active      (active),
    .raw         (raw),
    .block_bits  (block_bits),
    .master_bits (master_bits),
    .cfg_we      (cfg_we),
    .cfg_line    (cfg_line),
    .cfg_data    (cfg_data),
    .cfg_clr     (cfg_clr)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit;
    assign hit = cfg_we && (cfg_line == LINE_W'(i));
    irq_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .line_in   (irq_lines[i]),
      .cfg_hit   (hit),
      .cfg_wdata (cfg_data),
      .cfg_clr   (cfg_clr),
      .raw_lvl   (raw[i]),
      .active    (active[i])
    );
  end

  irq_status_tree #(
    .NUM_LINES         (NUM_LINES),
    .LINES_PER_BLOCK   (LINES_PER_BLOCK),
    .BLOCKS_PER_MASTER (BLOCKS_PER_MASTER)
  ) u_tree (
    .active      (active),
    .block_bits  (block_bits),
    .master_bits (master_bits),
    .host_irq    (host_irq)
  );

  // R10: no active line means a quiet host output
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (active == '0) |-> !host_irq);

  // R10: any active line reaches the host output
  assert_raise_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (active != '0) |-> host_irq);
endmodule

// File: tb/irq_tree_ctrl_tb.sv
module irq_tree_ctrl_tb;
  localparam logic [9:0] A_ROOT = 10'h1BB;
  localparam logic [9:0] A_MST  = 10'h1BC;
  localparam logic [9:0] A_SEL  = 10'h1C0;
  localparam logic [9:0] A_STAT = 10'h1C1;
  localparam logic [9:0] A_CFG  = 10'h1C2;
  localparam logic [9:0] A_RAW  = 10'h1C3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [9:0]   bus_addr;
  logic         bus_wr;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic [255:0] irq_lines;
  logic         host_irq;

  int total = 0;
  int bad   = 0;

  irq_tree_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .host_irq  (host_irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_addr  = 10'h000;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
    bus_addr = 10'h000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp8;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    irq_lines = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1: reset state
    check("R1 host", 32'(host_irq), 0);
    rd(A_ROOT, d); check("R1 root", 32'(d), 0);
    rd(A_SEL, d);  check("R1 select", 32'(d), 0);
    for (int k = 0; k < 4; k++) begin
      rd(A_MST + 10'(k), d); check("R1 master", 32'(d), 0);
    end
    rd(A_STAT, d); check("R1 status", 32'(d), 0);

    // R3 R5 R7 R8 R10: sweep of every line, trigger type rotating by index
    for (int i = 0; i < 256; i++) begin
      int blk, b, m, ty;
      logic exp_rise;
      blk = i / 8; b = i % 8; m = blk / 8; ty = i % 3;
      wr(A_SEL, 8'(blk));
      wr(A_CFG, 8'h80 | 8'(b << 4) | (ty == 0 ? 8'h02 : (ty == 1 ? 8'h04 : 8'h00)));
      irq_lines[i] = 1'b1;
      cyc(2);
      check("R5 latency", 32'(host_irq), 0);
      cyc(1);
      exp_rise = (ty != 1);
      check("R5 rise capture", 32'(host_irq), 32'(exp_rise));
      if (exp_rise) begin
        rd(A_ROOT, d); check("R3 root", 32'(d), 32'(1 << (m + 1)));
        rd(A_MST + 10'(m), d); check("R3 master", 32'(d), 32'(1 << (blk % 8)));
        rd(A_STAT, d); check("R8 status", 32'(d), 32'(1 << b));
      end
      irq_lines[i] = 1'b0;
      cyc(3);
      check("R5 held or fall", 32'(host_irq), 1);
      rd(A_STAT, d); check("R8 status after fall", 32'(d), 32'(1 << b));
      wr(A_CFG, 8'h8E | 8'(b << 4));
      check("R7 ack", 32'(host_irq), 0);
      rd(A_ROOT, d); check("R10 root after ack", 32'(d), 0);
    end

    // R8 R7: masked pending hides and reappears; unmask re-arms edges
    wr(A_SEL, 8'd1);
    wr(A_CFG, 8'hA2);
    irq_lines[10] = 1'b1; cyc(3);
    wr(A_CFG, 8'hA6);
    rd(A_STAT, d); check("R8 masked hidden", 32'(d), 0);
    check("R10 masked host", 32'(host_irq), 0);
    wr(A_CFG, 8'hA2);
    rd(A_STAT, d); check("R8 unmasked returns", 32'(d), 32'h04);
    check("R10 unmasked host", 32'(host_irq), 1);
    irq_lines[10] = 1'b0;
    wr(A_CFG, 8'hAE);
    wr(A_CFG, 8'hA2);
    cyc(2);
    check("R7 unmask no spurious", 32'(host_irq), 0);
    irq_lines[10] = 1'b1; cyc(3);
    check("R7 re-armed", 32'(host_irq), 1);
    irq_lines[10] = 1'b0;
    wr(A_CFG, 8'hAE);
    check("R7 ack again", 32'(host_irq), 0);

    // R4: write without bit7 ignored
    wr(A_SEL, 8'd2);
    wr(A_CFG, 8'h42);
    irq_lines[20] = 1'b1; cyc(3);
    check("R4 no-we host", 32'(host_irq), 0);
    rd(A_STAT, d); check("R4 no-we status", 32'(d), 0);
    irq_lines[20] = 1'b0; cyc(3);

    // R6: level mode, high-true then low-true
    wr(A_SEL, 8'd12);
    wr(A_CFG, 8'hC3);
    cyc(2);
    check("R6 high-true idle", 32'(host_irq), 0);
    irq_lines[100] = 1'b1; cyc(3);
    check("R6 high-true set", 32'(host_irq), 1);
    rd(A_STAT, d); check("R6 status", 32'(d), 32'h10);
    irq_lines[100] = 1'b0; cyc(3);
    check("R6 follows low", 32'(host_irq), 0);
    wr(A_CFG, 8'hC7);
    wr(A_CFG, 8'hD5);
    cyc(2);
    check("R6 low-true set", 32'(host_irq), 1);
    irq_lines[101] = 1'b1; cyc(3);
    check("R6 low-true drops", 32'(host_irq), 0);
    irq_lines[101] = 1'b0; cyc(3);
    check("R6 low-true again", 32'(host_irq), 1);
    wr(A_CFG, 8'hDF);
    cyc(1);
    check("R6 level masked", 32'(host_irq), 0);

    // R9 R11: raw level and select readback for every block
    for (int i = 0; i < 256; i++) irq_lines[i] = (((i * 5) + (i / 8)) % 3) == 0;
    cyc(3);
    for (int blk = 0; blk < 32; blk++) begin
      wr(A_SEL, 8'(blk) | 8'hE0);
      rd(A_SEL, d); check("R11 select", 32'(d), 32'(blk));
      exp8 = '0;
      for (int b = 0; b < 8; b++) exp8[b] = (((blk * 8 + b) * 5 + blk) % 3) == 0;
      rd(A_RAW, d); check("R9 raw", 32'(d), 32'(exp8));
    end
    check("R10 masked lines quiet", 32'(host_irq), 0);
    irq_lines = '0;
    cyc(3);

    // R2: unmapped addresses
    rd(10'h1BA, d); check("R2 below map", 32'(d), 0);
    rd(10'h1C4, d); check("R2 above map", 32'(d), 0);
    wr(A_SEL, 8'd9);
    wr(10'h1C4, 8'd5);
    wr(10'h1BA, 8'd6);
    rd(A_SEL, d); check("R2 stray write", 32'(d), 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule